// File: doc/BRIEF.md
# Serial Channel Bit Clock Generator

This block produces the bit-rate timing for one serial channel. It never creates a derived clock net. All timing leaves the block as single-cycle enables on the main clock. A two-bit source code picks a prescaled tick rate from the main clock: every cycle, every 8th cycle or every 32nd cycle. A down-counting reload divider then stretches that tick by n+1, where n is an 8-bit reload value.

In asynchronous mode, a further divide-by-16 stage gives the bit enable. The transmitter and the receiver use this enable in the same cycle. In synchronous mode, the channel either makes its own serial clock or follows an external clock pin. When it makes its own clock, the output toggles on every divider pulse and is driven out. When it follows the pin, the pin is synchronized, optionally inverted and edge-detected. A build parameter can fix the channel to asynchronous operation only.

The transmit data line can be steered to one of two output pins and gated by an enable.

Top module: `serclk_gen`

## Requirements
- R1: Source code 00 gives a tick every cycle, 01 every 8 cycles, 10 every 32 cycles, and the reserved code 11 behaves like 00. The prescale factor is written P below.
- R2: The reload divider emits one pulse every n+1 source ticks.
- R3: In asynchronous mode (`sync_mode`=0), `tx_bit_en` and `rx_bit_en` pulse together for one cycle, once every 16·(n+1)·P cycles.
- R4: A new reload value does not change the divider period in progress; it applies from the next divider reload onward.
- R5: In internal synchronous mode (`sync_mode`=1, `ext_dir`=0), `sclk_oe` is 1 and `sclk_out` toggles on every divider pulse. `rx_bit_en` pulses on each low-to-high toggle and `tx_bit_en` on each high-to-low toggle, so each enable repeats every 2·(n+1)·P cycles and rx leads tx by (n+1)·P cycles.
- R6: In external synchronous mode (`sync_mode`=1, `ext_dir`=1), `sclk_oe` is 0. A rising edge of `ext_clk` gives one `rx_bit_en` pulse and a falling edge gives one `tx_bit_en` pulse, each within 3 cycles of the pin change.
- R7: With `ext_invert`=1 in external mode, the edge roles swap: a rising pin edge gives `tx_bit_en` and a falling edge gives `rx_bit_en`.
- R8: With parameter UART_ONLY=1, `sync_mode` and `ext_dir` are ignored. The channel always uses the asynchronous divide-by-16 timing and never drives `sclk_oe`.
- R9: When `txd_out_en`=1, `txd_pin_a` follows `txd_data` if `txd_pin_sel`=0 and `txd_pin_b` follows it if `txd_pin_sel`=1. The unselected pin, and both pins when `txd_out_en`=0, sit at 1.
- R10: In reset, both bit enables are 0 and `sclk_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Prescaler source code |
| reload | input | 8 | Divider reload value n |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| ext_dir | input | 1 | Synchronous clock source: 0 internal, 1 external pin |
| ext_invert | input | 1 | Invert the external clock |
| ext_clk | input | 1 | External serial clock pin (asynchronous) |
| txd_data | input | 1 | Transmit data from the shifter |
| txd_pin_sel | input | 1 | Select transmit pin A (0) or B (1) |
| txd_out_en | input | 1 | Transmit output enable |
| tx_bit_en | output | 1 | Transmit bit enable pulse |
| rx_bit_en | output | 1 | Receive bit enable pulse |
| sclk_out | output | 1 | Internally generated serial clock |
| sclk_oe | output | 1 | Drive enable for sclk_out |
| txd_pin_a | output | 1 | Transmit pin A |
| txd_pin_b | output | 1 | Transmit pin B |

## Verification
The bench sweeps every source code, including the reserved one, across several reload values and measures pulse spacing in asynchronous and internal synchronous modes. A wrong prescale decode or an off-by-one in the divider shows up as a wrong cycle count. The bench also changes the reload value in the middle of a period. A design that loads the new value at once would cut the running period short instead of finishing it at the old length. The bench toggles the external pin with and without inversion: swapped edge roles, missing pulses, or a clock driven out in external mode each fail a check. A second instance built for asynchronous-only use is given synchronous settings. A design that obeyed those settings would change its enable spacing or drive the clock pin.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_RSVD  = 2'b11
  } src_sel_e;

  // Pick the prescaled tick for a source code; reserved code acts as DIV1.
  function automatic logic pick_src_tick(input src_sel_e sel,
                                         input logic tick_mid,
                                         input logic tick_slow);
    case (sel)
      SRC_DIV8:  return tick_mid;
      SRC_DIV32: return tick_slow;
      default:   return 1'b1;
    endcase
  endfunction

  // Cycles between asynchronous bit enables for a given prescale factor.
  function automatic int unsigned async_bit_cycles(input int unsigned pre,
                                                   input int unsigned n,
                                                   input int unsigned os);
    return os * (n + 1) * pre;
  endfunction

endpackage

// File: rtl/serclk_prescaler.sv
module serclk_prescaler
  import serclk_pkg::*;
#(
  parameter int PRE_W     = 5,
  parameter int MID_SHIFT = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_e sel,
  output logic     src_tick
);

  logic [PRE_W-1:0] pre_cnt;
  logic             tick_mid;
  logic             tick_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick_mid  = &pre_cnt[MID_SHIFT-1:0];
  assign tick_slow = &pre_cnt;
  assign src_tick  = pick_src_tick(sel, tick_mid, tick_slow);

  // R1: slow taps never fire on back-to-back cycles
  assert_mid_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_mid |=> !tick_mid);
  assert_slow_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |=> !tick_slow);

endmodule

// File: rtl/serclk_reload_div.sv
module serclk_reload_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] reload,
  output logic             div_pulse
);

  logic [DIV_W-1:0] cnt;
  logic             at_zero;

  assign at_zero   = (cnt == '0);
  assign div_pulse = src_tick & at_zero;

  // Reload value is sampled only at underflow, so a running period keeps its length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (div_pulse)  cnt <= reload;
    else if (src_tick)   cnt <= cnt - 1'b1;
  end

  // R2: between pulses the counter only moves on source ticks
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |=> $stable(cnt));

endmodule

// File: rtl/serclk_ext_sync.sv
module serclk_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  input  logic invert,
  output logic edge_rise,
  output logic edge_fall
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   level;
  logic                   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], ext_pin};
  end

  assign level = chain[SYNC_STAGES-1] ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign edge_rise = level & ~level_q;
  assign edge_fall = ~level & level_q;

  // R6: a single synchronized sample never yields both edges
  assert_one_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edge_rise, edge_fall}));

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import serclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int OS_W        = 4,
  parameter int PRE_W       = 5,
  parameter int MID_SHIFT   = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit UART_ONLY   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] reload,
  input  logic             sync_mode,
  input  logic             ext_dir,
  input  logic             ext_invert,
  input  logic             ext_clk,
  input  logic             txd_data,
  input  logic             txd_pin_sel,
  input  logic             txd_out_en,
  output logic             tx_bit_en,
  output logic             rx_bit_en,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             txd_pin_a,
  output logic             txd_pin_b
);

  localparam int NUM_PINS = 2;

  logic              src_tick;
  logic              div_pulse;
  logic              ext_rise;
  logic              ext_fall;
  logic              uart_eff;
  logic              int_sync;
  logic              ext_sync;
  logic [OS_W-1:0]   os_cnt;
  logic              os_wrap;
  logic              sclk_q;
  logic [NUM_PINS-1:0] pin_vec;

  assign uart_eff = UART_ONLY || !sync_mode;
  assign int_sync = !uart_eff && !ext_dir;
  assign ext_sync = !uart_eff && ext_dir;

  serclk_prescaler #(.PRE_W(PRE_W), .MID_SHIFT(MID_SHIFT)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (src_sel_e'(src_sel)),
    .src_tick (src_tick)
  );

  serclk_reload_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .reload    (reload),
    .div_pulse (div_pulse)
  );

  serclk_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pin   (ext_clk),
    .invert    (ext_invert),
    .edge_rise (ext_rise),
    .edge_fall (ext_fall)
  );

  // Oversampling stage for asynchronous mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         os_cnt <= '0;
    else if (!uart_eff) os_cnt <= '0;
    else if (div_pulse) os_cnt <= os_cnt + 1'b1;
  end

  assign os_wrap = div_pulse && (os_cnt == {OS_W{1'b1}});

  // Internal serial clock, idle high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sclk_q <= 1'b1;
    else if (!int_sync)             sclk_q <= 1'b1;
    else if (div_pulse)             sclk_q <= ~sclk_q;
  end

  always_comb begin
    if (uart_eff) begin
      tx_bit_en = os_wrap;
      rx_bit_en = os_wrap;
    end else if (int_sync) begin
      tx_bit_en = div_pulse & sclk_q;
      rx_bit_en = div_pulse & ~sclk_q;
    end else begin
      tx_bit_en = ext_fall;
      rx_bit_en = ext_rise;
    end
  end

  assign sclk_out = sclk_q;
  assign sclk_oe  = int_sync;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_vec[p] = (txd_out_en && (txd_pin_sel == p[0])) ? txd_data : 1'b1;
  end

  assign txd_pin_a = pin_vec[0];
  assign txd_pin_b = pin_vec[1];

  // R2: divider pulses only on a prescaled tick (crosses two submodules)
  assert_div_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> src_tick);

  // R3: asynchronous bit enables arise only from a divider pulse
  assert_async_from_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_eff && tx_bit_en) |-> (div_pulse && rx_bit_en));

  // R5: internal clock flips after each divider pulse
  assert_sclk_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sync && div_pulse) |=> (!int_sync || sclk_out != $past(sclk_out)));

  // R6: external mode never drives the clock pin
  assert_ext_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync |-> !sclk_oe);

  // R8: asynchronous-only build never drives the clock and keeps enables paired
  if (UART_ONLY) begin : g_uo_chk
    assert_uo_async_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_oe && (tx_bit_en == rx_bit_en));
  end

  // R9: disabled transmit output holds both pins at mark level
  assert_txd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_out_en |-> (txd_pin_a && txd_pin_b));

endmodule

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] reload = 8'd0;
  logic       sync_mode = 1'b0;
  logic       ext_dir = 1'b0;
  logic       ext_invert = 1'b0;
  logic       ext_clk = 1'b0;
  logic       txd_data = 1'b1;
  logic       txd_pin_sel = 1'b0;
  logic       txd_out_en = 1'b0;

  logic tx_en, rx_en, sclk_o, sclk_oe, pin_a, pin_b;
  logic uo_tx, uo_rx, uo_sclk, uo_oe, uo_a, uo_b;

  int tests = 0;
  int fails = 0;
  int cyc_total = 0;

  always #4 clk = ~clk;

  serclk_gen u_serclk_gen (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .reload(reload),
    .sync_mode(sync_mode), .ext_dir(ext_dir), .ext_invert(ext_invert),
    .ext_clk(ext_clk), .txd_data(txd_data), .txd_pin_sel(txd_pin_sel),
    .txd_out_en(txd_out_en), .tx_bit_en(tx_en), .rx_bit_en(rx_en),
    .sclk_out(sclk_o), .sclk_oe(sclk_oe), .txd_pin_a(pin_a), .txd_pin_b(pin_b)
  );

  serclk_gen #(.UART_ONLY(1'b1)) u_serclk_gen_uo (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .reload(reload),
    .sync_mode(sync_mode), .ext_dir(ext_dir), .ext_invert(ext_invert),
    .ext_clk(ext_clk), .txd_data(txd_data), .txd_pin_sel(txd_pin_sel),
    .txd_out_en(txd_out_en), .tx_bit_en(uo_tx), .rx_bit_en(uo_rx),
    .sclk_out(uo_sclk), .sclk_oe(uo_oe), .txd_pin_a(uo_a), .txd_pin_b(uo_b)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 190000) begin
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc_total);
      fails = fails + 1;
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    case (w)
      0: return tx_en;
      1: return rx_en;
      2: return uo_tx;
      default: return uo_rx;
    endcase
  endfunction

  // Wait for a pulse on 'from', then count cycles until a pulse on 'to'.
  task automatic gap(input int from, input int to, output int cyc);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!pick(from) && guard < 20000);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!pick(to) && cyc < 20000);
  endtask

  function automatic int pre_factor(input int s);
    if (s == 1) return 8;
    if (s == 2) return 32;
    return 1;
  endfunction

  int got;
  int rcnt, tcnt;

  task automatic ext_edge(input logic lvl, input string req, input int exp_rx, input int exp_tx);
    @(negedge clk);
    ext_clk = lvl;
    rcnt = 0;
    tcnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rcnt += rx_en;
      tcnt += tx_en;
    end
    check(rcnt == exp_rx, req, rcnt, exp_rx);
    check(tcnt == exp_tx, req, tcnt, exp_tx);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(tx_en == 1'b0 && rx_en == 1'b0, "R10 enables", {tx_en, rx_en}, 0);
    check(sclk_o == 1'b1, "R10 sclk_out", sclk_o, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3: asynchronous sweep over every source code and two reload values
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 5; n += 3) begin
        @(negedge clk);
        src_sel = 2'(s);
        reload = 8'(n);
        gap(0, 0, got);
        gap(0, 1, got);
        check(got == ((n + 1) << 4) * pre_factor(s), $sformatf("R3 R1 sel=%0d n=%0d", s, n),
              got, ((n + 1) << 4) * pre_factor(s));
      end
    end
    @(negedge clk);
    src_sel = 2'd2;
    reload = 8'd7;
    gap(0, 0, got);
    gap(0, 1, got);
    check(got == 4096, "R3 R2 sel=2 n=7", got, 4096);

    // R5 R2: internal synchronous mode
    @(negedge clk);
    sync_mode = 1'b1;
    ext_dir = 1'b0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      src_sel = 2'd0;
      reload = 8'(n);
      gap(1, 1, got);
      gap(1, 1, got);
      check(got == 2 * (n + 1), $sformatf("R5 R2 rx period n=%0d", n), got, 2 * (n + 1));
      gap(1, 0, got);
      check(got == n + 1, $sformatf("R5 rx to tx n=%0d", n), got, n + 1);
    end
    for (int s = 1; s < 3; s++) begin
      @(negedge clk);
      src_sel = 2'(s);
      reload = 8'd3;
      gap(0, 0, got);
      gap(0, 0, got);
      check(got == 8 * pre_factor(s), $sformatf("R5 R1 tx period sel=%0d", s), got, 8 * pre_factor(s));
    end
    check(sclk_oe == 1'b1, "R5 sclk_oe", sclk_oe, 1);

    // R4: change reload mid-period
    @(negedge clk);
    src_sel = 2'd0;
    reload = 8'd9;
    gap(1, 1, got);
    gap(1, 1, got);
    got = 0;
    do begin
      @(negedge clk);
      got++;
      if (got == 1) reload = 8'd3;
    end while (!tx_en && got < 1000);
    check(got == 10, "R4 running period keeps old length", got, 10);
    got = 0;
    do begin
      @(negedge clk);
      got++;
    end while (!rx_en && got < 1000);
    check(got == 4, "R4 new value after reload", got, 4);

    // R6 R7: external clock with and without inversion
    @(negedge clk);
    ext_dir = 1'b1;
    ext_invert = 1'b0;
    ext_clk = 1'b0;
    repeat (6) @(negedge clk);
    check(sclk_oe == 1'b0, "R6 sclk_oe", sclk_oe, 0);
    for (int k = 0; k < 3; k++) begin
      ext_edge(1'b1, "R6 rising", 1, 0);
      ext_edge(1'b0, "R6 falling", 0, 1);
    end
    @(negedge clk);
    ext_invert = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      ext_edge(1'b1, "R7 rising inverted", 0, 1);
      ext_edge(1'b0, "R7 falling inverted", 1, 0);
    end

    // R8: asynchronous-only build ignores synchronous settings
    @(negedge clk);
    src_sel = 2'd0;
    reload = 8'd1;
    gap(2, 2, got);
    gap(2, 3, got);
    check(got == 32, "R8 async period under sync settings", got, 32);
    check(uo_oe == 1'b0, "R8 no clock drive", uo_oe, 0);
    @(negedge clk);
    ext_dir = 1'b0;
    gap(2, 2, got);
    gap(2, 3, got);
    check(got == 32, "R8 async period internal setting", got, 32);

    // R9: transmit pin steering
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      txd_out_en = c[2];
      txd_pin_sel = c[1];
      txd_data = c[0];
      #1;
      check(pin_a == ((c[2] && !c[1]) ? c[0] : 1'b1), $sformatf("R9 pin_a c=%0d", c), pin_a,
            (c[2] && !c[1]) ? int'(c[0]) : 1);
      check(pin_b == ((c[2] && c[1]) ? c[0] : 1'b1), $sformatf("R9 pin_b c=%0d", c), pin_b,
            (c[2] && c[1]) ? int'(c[0]) : 1);
    end

    summary();
  end

endmodule